// File: doc/BRIEF.md
# Dual-Accumulator ALU with Sticky Overflow Tracking

This block is the arithmetic and logic stage of a 16-bit signal-processing datapath. It keeps two accumulators, A and B, and each has a six-bit flag set of its own. In each enabled cycle it takes a 4-bit operation code, picks one accumulator, and combines it with a P operand. The result and the new flags are written back into that accumulator on the next clock edge. The operand mux in front of P and the multiplier are outside this block. P arrives already selected.

Two features set this block apart from a plain ALU. The first is a second overflow flag that collects overflows across a chain of additions. It cancels when two overflows in a row go in opposite directions. A sign flag tied to it holds its value while that overflow is pending. The second feature is cross-coupled carry: the carry-dependent operations on one accumulator take their carry-in from the other accumulator's flags. This lets a wide add be split across A and B.

Top module: `dacc_alu`

## Requirements
- R1: After reset both accumulators are zero and both flag outputs are zero.
- R2: When `en` is low, or when the code is 0 (no operation), neither accumulator and neither flag set changes on the clock edge.
- R3: An operation writes only the accumulator and flag set chosen by `acc_sel` (0 selects A, 1 selects B). The other accumulator and its flags keep their values.
- R4: Code 1 is OR, 2 is AND and 3 is XOR with P. Code 10 is NOT of the accumulator and code 15 swaps its upper and lower bytes. These codes, and also 13 and 14, clear ov0, ov1 and c.
- R5: Code 11 is an arithmetic shift right by one with c taken from the old bit 0. Code 12 is a shift left by one: it shifts in the other accumulator's c and sets c to the old bit 15. Code 13 shifts left by two and fills with 11b; code 14 shifts left by four and fills with 1111b. Codes 11 and 12 clear ov0 and ov1.
- R6: Code 4 is accumulator minus P and code 5 is accumulator plus P. Code 8 decrements by one and code 9 increments by one. The result wraps at 16 bits, and c is the carry (for additions) or borrow (for subtractions) out of bit 15.
- R7: Code 7 (add with carry) and code 6 (subtract with borrow) use the c flag of the accumulator that is not selected.
- R8: The flag outputs are packed as ov0 in bit 0, ov1 in bit 1, z in bit 2, c in bit 3, s0 in bit 4 and s1 in bit 5. After any operation, z is set exactly when the new result is zero, and s0 equals bit 15 of the new result.
- R9: For codes 4 to 9, ov0 is set exactly when the signed two's-complement result overflows 16 bits. All other operations clear ov0.
- R10: For codes 4 to 9, ov1 depends on the new ov0 and the previous ov1:
  - if both are set, the new ov1 is set when the new s0 equals the new s1;
  - otherwise the new ov1 is the OR of the new ov0 and the previous ov1.
- R11: s1 takes the new s0 when the previous ov1 was clear, and otherwise keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Enables the write-back for this cycle |
| op | input | 4 | Operation code |
| acc_sel | input | 1 | 0 selects accumulator A, 1 selects B |
| p_in | input | 16 | P operand |
| acc_a | output | 16 | Accumulator A |
| acc_b | output | 16 | Accumulator B |
| flg_a | output | 6 | Flag set of A |
| flg_b | output | 6 | Flag set of B |

## Verification
The hardest case to reach is the cancelling branch of ov1. It needs a pending ov1 while s1 is frozen, followed by a second overflow whose sign disagrees with the frozen s1. Any logic or shift operation in between wipes out that history. The bench reaches this branch in two ways. A directed sequence preloads 0x7FFF, adds one and then subtracts one. A long phase then issues only additions and subtractions with operands biased towards large magnitudes, with a flag-clearing operation only rarely. A behavioural model of both accumulators and flag sets predicts every cycle.

// File: rtl/dacc_pkg.sv
package dacc_pkg;

    localparam int NACC = 2;

    typedef enum logic [3:0] {
        OP_NOP  = 4'd0,
        OP_OR   = 4'd1,
        OP_AND  = 4'd2,
        OP_XOR  = 4'd3,
        OP_SUB  = 4'd4,
        OP_ADD  = 4'd5,
        OP_SBB  = 4'd6,
        OP_ADC  = 4'd7,
        OP_DEC  = 4'd8,
        OP_INC  = 4'd9,
        OP_NOT  = 4'd10,
        OP_ASR1 = 4'd11,
        OP_SHL1 = 4'd12,
        OP_SHL2 = 4'd13,
        OP_SHL4 = 4'd14,
        OP_SWAP = 4'd15
    } alu_op_e;

    // How an operation treats the carry and overflow flags
    typedef enum logic [1:0] {
        CLS_LOGIC,
        CLS_ARITH,
        CLS_SHR,
        CLS_SHL
    } op_cls_e;

    // Packed so that ov0 lands in bit 0 and s1 in bit 5
    typedef struct packed {
        logic s1;
        logic s0;
        logic c;
        logic z;
        logic ov1;
        logic ov0;
    } flags_t;

    function automatic op_cls_e op_class(alu_op_e op);
        case (op)
            OP_SUB, OP_ADD, OP_SBB, OP_ADC, OP_DEC, OP_INC: op_class = CLS_ARITH;
            OP_ASR1: op_class = CLS_SHR;
            OP_SHL1: op_class = CLS_SHL;
            default: op_class = CLS_LOGIC;
        endcase
    endfunction

endpackage

// File: rtl/dacc_datapath.sv
module dacc_datapath
    import dacc_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [3:0]   op_code,
    input  logic [W-1:0] q,
    input  logic [W-1:0] p,
    input  logic         cin,
    output logic [W-1:0] r,
    output logic         arith_c,
    output logic         ovf
);
    localparam int MSB  = W - 1;
    localparam int HALF = W / 2;

    alu_op_e      op;
    logic [W-1:0] p_eff;
    logic [W-1:0] second;
    logic [W-1:0] carries;
    logic [W-1:0] ovf_vec;

    assign op = alu_op_e'(op_code);

    always_comb begin
        // Increment and decrement reuse the adder with a unit operand
        p_eff = ((op == OP_DEC) || (op == OP_INC)) ? W'(1) : p;
        case (op)
            OP_OR:   r = q | p_eff;
            OP_AND:  r = q & p_eff;
            OP_XOR:  r = q ^ p_eff;
            OP_SUB:  r = q - p_eff;
            OP_ADD:  r = q + p_eff;
            OP_SBB:  r = q - p_eff - W'(cin);
            OP_ADC:  r = q + p_eff + W'(cin);
            OP_DEC:  r = q - p_eff;
            OP_INC:  r = q + p_eff;
            OP_NOT:  r = ~q;
            OP_ASR1: r = {q[MSB], q[MSB:1]};
            OP_SHL1: r = {q[MSB-1:0], cin};
            OP_SHL2: r = {q[MSB-2:0], 2'b11};
            OP_SHL4: r = {q[MSB-4:0], 4'hF};
            OP_SWAP: r = {q[HALF-1:0], q[MSB:HALF]};
            default: r = q;
        endcase
        // Carry into the top bit and signed overflow, shared by add and subtract
        carries = q ^ p_eff ^ r;
        second  = op_code[0] ? r : q;
        ovf_vec = (q ^ r) & (p_eff ^ second);
        ovf     = ovf_vec[MSB];
        arith_c = carries[MSB] ^ ovf;
    end

endmodule

// File: rtl/dacc_flagupd.sv
module dacc_flagupd
    import dacc_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [3:0]   op_code,
    input  logic [W-1:0] r,
    input  logic         q_lo,
    input  logic         q_hi,
    input  logic         arith_c,
    input  logic         ovf,
    input  flags_t       old_f,
    output flags_t       new_f
);
    localparam int MSB = W - 1;

    op_cls_e cls;

    assign cls = op_class(alu_op_e'(op_code));

    always_comb begin
        new_f.z  = (r == '0);
        new_f.s0 = r[MSB];
        // The saturation sign holds while a sticky overflow is pending
        new_f.s1 = old_f.ov1 ? old_f.s1 : r[MSB];
        new_f.ov0 = 1'b0;
        new_f.ov1 = 1'b0;
        new_f.c   = 1'b0;
        case (cls)
            CLS_ARITH: begin
                new_f.ov0 = ovf;
                new_f.c   = arith_c;
                if (ovf && old_f.ov1) begin
                    new_f.ov1 = (new_f.s0 == new_f.s1);
                end else begin
                    new_f.ov1 = ovf | old_f.ov1;
                end
            end
            CLS_SHR: new_f.c = q_lo;
            CLS_SHL: new_f.c = q_hi;
            default: new_f.c = 1'b0;
        endcase
    end

endmodule

// File: rtl/dacc_regbank.sv
module dacc_regbank
    import dacc_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         we,
    input  logic         sel,
    input  logic [W-1:0] r,
    input  flags_t       new_f,
    output logic [W-1:0] acc [NACC],
    output flags_t       flg [NACC]
);

    for (genvar i = 0; i < NACC; i++) begin : g_acc
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                acc[i] <= '0;
                flg[i] <= '0;
            end else if (we && (sel == 1'(i))) begin
                acc[i] <= r;
                flg[i] <= new_f;
            end
        end
    end

endmodule

// File: rtl/dacc_alu.sv
module dacc_alu
    import dacc_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic [3:0]   op,
    input  logic         acc_sel,
    input  logic [W-1:0] p_in,
    output logic [W-1:0] acc_a,
    output logic [W-1:0] acc_b,
    output logic [5:0]   flg_a,
    output logic [5:0]   flg_b
);
    logic [W-1:0] acc [NACC];
    flags_t       flg [NACC];
    logic [W-1:0] q;
    logic [W-1:0] r;
    flags_t       old_f;
    flags_t       new_f;
    logic         cin;
    logic         arith_c;
    logic         ovf;
    logic         we;

    assign q     = acc[acc_sel];
    assign old_f = flg[acc_sel];
    // Carry-in is always taken from the accumulator that is not selected
    assign cin   = flg[~acc_sel].c;
    assign we    = en && (op != OP_NOP);

    dacc_datapath #(.W(W)) u_dp (
        .op_code (op),
        .q       (q),
        .p       (p_in),
        .cin     (cin),
        .r       (r),
        .arith_c (arith_c),
        .ovf     (ovf)
    );

    dacc_flagupd #(.W(W)) u_flg (
        .op_code (op),
        .r       (r),
        .q_lo    (q[0]),
        .q_hi    (q[W-1]),
        .arith_c (arith_c),
        .ovf     (ovf),
        .old_f   (old_f),
        .new_f   (new_f)
    );

    dacc_regbank #(.W(W)) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (we),
        .sel   (acc_sel),
        .r     (r),
        .new_f (new_f),
        .acc   (acc),
        .flg   (flg)
    );

    assign acc_a = acc[0];
    assign acc_b = acc[1];
    assign flg_a = flg[0];
    assign flg_b = flg[1];

endmodule

// File: rtl/dacc_alu_chk.sv
module dacc_alu_chk
    import dacc_pkg::*;
#(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic         en,
    input logic [3:0]   op,
    input logic         acc_sel,
    input logic [W-1:0] acc_a,
    input logic [W-1:0] acc_b,
    input logic [5:0]   flg_a,
    input logic [5:0]   flg_b
);
    logic active;
    logic clr_all;
    logic is_shift1;

    assign active    = en && (op != OP_NOP);
    assign clr_all   = (op == OP_OR) || (op == OP_AND) || (op == OP_XOR) || (op == OP_NOT)
                    || (op == OP_SHL2) || (op == OP_SHL4) || (op == OP_SWAP);
    assign is_shift1 = (op == OP_ASR1) || (op == OP_SHL1);

    assert_hold_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> $stable({acc_a, acc_b, flg_a, flg_b}));

    assert_b_untouched_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !acc_sel) |=> $stable({acc_b, flg_b}));

    assert_a_untouched_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (active && acc_sel) |=> $stable({acc_a, flg_a}));

    assert_logic_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (en && clr_all) |=> ($past(acc_sel) ? {flg_b[3], flg_b[1:0]} : {flg_a[3], flg_a[1:0]}) == 3'b000);

    assert_shift_noov_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (en && is_shift1) |=> ($past(acc_sel) ? flg_b[1:0] : flg_a[1:0]) == 2'b00);

    assert_zero_sign_a_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !acc_sel) |=> (flg_a[2] == (acc_a == '0)) && (flg_a[4] == acc_a[W-1]));

    assert_zero_sign_b_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (active && acc_sel) |=> (flg_b[2] == (acc_b == '0)) && (flg_b[4] == acc_b[W-1]));

    assert_s1_frozen_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !acc_sel && flg_a[1]) |=> $stable(flg_a[5]));

endmodule

bind dacc_alu dacc_alu_chk #(.W(W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (en),
    .op      (op),
    .acc_sel (acc_sel),
    .acc_a   (acc_a),
    .acc_b   (acc_b),
    .flg_a   (flg_a),
    .flg_b   (flg_b)
);

// File: tb/dacc_alu_tb_top.sv
module dacc_alu_tb_top;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         en = 1'b0;
    logic [3:0]   op = 4'd0;
    logic         acc_sel = 1'b0;
    logic [W-1:0] p_in = '0;
    logic [W-1:0] acc_a, acc_b;
    logic [5:0]   flg_a, flg_b;

    logic [15:0] ma = '0, mb = '0;
    logic [5:0]  fa = '0, fb = '0;
    int nchk = 0;
    int nerr = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    dacc_alu #(.W(W)) dut_i (
        .clk(clk), .rst_n(rst_n), .en(en), .op(op), .acc_sel(acc_sel),
        .p_in(p_in), .acc_a(acc_a), .acc_b(acc_b), .flg_a(flg_a), .flg_b(flg_b)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        nchk++;
        if (got !== exp) begin
            nerr++;
            $display("FAIL %s: got %h expected %h (t=%0t)", tag, got, exp, $time);
        end
    endtask

    function automatic string op_tag(input bit e, input int c);
        if (!e || c == 0) return "R2";
        case (c)
            1, 2, 3, 10, 15: return "R4";
            11, 12, 13, 14:  return "R5";
            6, 7:            return "R7";
            default:         return "R6";
        endcase
    endfunction

    // Behavioural model built from the requirements, using integer arithmetic
    task automatic model_apply(input bit e, input int c, input bit s, input logic [15:0] p);
        logic [15:0] q, r;
        logic [5:0]  of, nf;
        logic [16:0] full;
        logic        cin, cy, ov0, arith;
        int          sv;
        if (!e || c == 0) return;
        q = s ? mb : ma;
        of = s ? fb : fa;
        cin = s ? fa[3] : fb[3];
        arith = 1'b0; cy = 1'b0; ov0 = 1'b0; full = '0; sv = 0; r = q;
        case (c)
            1:  r = q | p;
            2:  r = q & p;
            3:  r = q ^ p;
            4:  begin full = {1'b0, q} - {1'b0, p}; sv = int'($signed(q)) - int'($signed(p)); arith = 1'b1; end
            5:  begin full = {1'b0, q} + {1'b0, p}; sv = int'($signed(q)) + int'($signed(p)); arith = 1'b1; end
            6:  begin full = {1'b0, q} - {1'b0, p} - 17'(cin); sv = int'($signed(q)) - int'($signed(p)) - int'(cin); arith = 1'b1; end
            7:  begin full = {1'b0, q} + {1'b0, p} + 17'(cin); sv = int'($signed(q)) + int'($signed(p)) + int'(cin); arith = 1'b1; end
            8:  begin full = {1'b0, q} - 17'd1; sv = int'($signed(q)) - 1; arith = 1'b1; end
            9:  begin full = {1'b0, q} + 17'd1; sv = int'($signed(q)) + 1; arith = 1'b1; end
            10: r = ~q;
            11: begin r = {q[15], q[15:1]}; cy = q[0]; end
            12: begin r = {q[14:0], cin}; cy = q[15]; end
            13: r = {q[13:0], 2'b11};
            14: r = {q[11:0], 4'hF};
            default: r = {q[7:0], q[15:8]};
        endcase
        if (arith) begin
            r = full[15:0];
            cy = full[16];
            ov0 = (sv > 32767) || (sv < -32768);
        end
        nf[2] = (r == 16'h0);
        nf[4] = r[15];
        nf[5] = of[1] ? of[5] : r[15];
        nf[3] = cy;
        nf[0] = ov0;
        if (arith) nf[1] = (ov0 && of[1]) ? (nf[4] == nf[5]) : (ov0 || of[1]);
        else       nf[1] = 1'b0;
        if (s) begin mb = r; fb = nf; end
        else   begin ma = r; fa = nf; end
    endtask

    task automatic compare_all(input bit e, input int c, input bit s);
        logic [5:0] gf, ef;
        chk(op_tag(e, c), s ? acc_b : acc_a, s ? mb : ma);
        chk("R3", s ? {acc_a, flg_a} : {acc_b, flg_b}, s ? {ma, fa} : {mb, fb});
        gf = s ? flg_b : flg_a;
        ef = s ? fb : fa;
        chk("R8", {gf[4], gf[2]}, {ef[4], ef[2]});
        chk("R9", gf[0], ef[0]);
        chk(op_tag(e, c), gf[3], ef[3]);
        chk("R10", gf[1], ef[1]);
        chk("R11", gf[5], ef[5]);
    endtask

    // Called just after a falling edge; returns just after the next one
    task automatic run_op(input bit e, input int c, input bit s, input logic [15:0] p);
        en = e; op = 4'(c); acc_sel = s; p_in = p;
        @(posedge clk);
        @(negedge clk);
        model_apply(e, c, s, p);
        compare_all(e, c, s);
    endtask

    function automatic logic [15:0] pick_p(input int k);
        case (k)
            0: return 16'h0000;
            1: return 16'h0001;
            2: return 16'h7FFF;
            3: return 16'h8000;
            4: return 16'hFFFF;
            5: return 16'h00FF;
            6: return 16'hFF00;
            7: return 16'h5555;
            default: return 16'($urandom);
        endcase
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", {acc_a, acc_b, flg_a, flg_b}, 44'h0);

        // Directed: sticky overflow set then cancelled by an opposite overflow
        run_op(1, 2, 0, 16'h0000);
        run_op(1, 1, 0, 16'h7FFF);
        run_op(1, 5, 0, 16'h0001);
        chk("R10", {acc_a, 10'h0, flg_a}, {16'h8000, 10'h0, 6'h33});
        run_op(1, 4, 0, 16'h0001);
        chk("R10", {acc_a, 10'h0, flg_a}, {16'h7FFF, 10'h0, 6'h21});

        // Directed: add with carry takes carry from the other accumulator
        run_op(1, 2, 1, 16'h0000);
        run_op(1, 1, 1, 16'hFFFF);
        run_op(1, 5, 1, 16'h0001);
        run_op(1, 2, 0, 16'h0000);
        run_op(1, 7, 0, 16'h0005);
        chk("R7", acc_a, 16'h0006);

        // Sweep every code on both accumulators with a random preceding operation
        for (int c = 0; c < 16; c++) begin
            for (int s = 0; s < 2; s++) begin
                for (int k = 0; k < 100; k++) begin
                    run_op(1, 1 + int'($urandom_range(14)), 1'($urandom), 16'($urandom));
                    run_op(1, c, 1'(s), pick_p(k));
                end
            end
        end

        // Overflow chains: arithmetic only, large operands, rare flag clears
        for (int k = 0; k < 3000; k++) begin
            if (k % 37 == 36) begin
                run_op(1, 2, 1'($urandom), 16'hFFFF);
            end else begin
                run_op(1, 4 + int'($urandom_range(3)), 1'($urandom),
                       (k % 2 == 0) ? (16'h6000 | 16'($urandom_range(16'h1FFF)))
                                    : (16'hA000 | 16'($urandom_range(16'h1FFF))));
            end
        end

        // Enable low: no code may change anything
        for (int k = 0; k < 64; k++) begin
            run_op(0, 1 + int'($urandom_range(14)), 1'($urandom), 16'($urandom));
        end

        en = 1'b0;
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            nchk++;
            nerr++;
            $display("FAIL watchdog: run did not complete, got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
            $finish;
        end
    end

endmodule